// File: doc/BRIEF.md
# Synchronous FIFO with Block-RAM Storage and Registered Read

This block is a single-clock first-in first-out buffer. Its entries are held in an inferred memory array with one write port and one read port, so that large depths map to on-chip RAM. By default the read port is registered. A read accepted at one clock edge presents its data on the next cycle, with a one-cycle valid strobe. The dequeue-side status (empty and almost-empty) is held back by the same cycle, so it stays aligned with the data the consumer sees.

The producer drives `wr_en` with `wr_data`. The consumer drives `rd_en` and takes `rd_data` when `rd_valid` is high. A write while the buffer is full is dropped, and so is a read while it is empty. A parameter switches the storage to an asynchronous read port. In that mode the head entry is visible combinationally, `rd_valid` rises in the same cycle as the accepted read, and the dequeue-side flags follow the occupancy without delay. Both almost thresholds are parameters.

Top module: `sync_ram_fifo`

## Requirements
- R1: While `rst_n` is low at a clock edge, the occupancy, both pointers and the valid strobe are cleared. After that edge `empty` and `almost_empty` read 1, and `full`, `almost_full` and `rd_valid` read 0. This holds whatever the buffer held before.
- R2: Data leaves in exactly the order it was accepted, with no loss and no duplication, under any mix of write and read enables.
- R3: With `ASYNC_RD`=0, a read accepted at clock edge N presents the head entry on `rd_data` after edge N. `rd_valid` is 1 for exactly that one cycle and is 0 after an edge with no accepted read.
- R4: `full` is 1 exactly when DEPTH entries are held. A write while full is dropped, and the stored contents stay unchanged.
- R5: A read while empty is dropped. It raises no `rd_valid`, and it moves no pointer, so later data still comes out correctly.
- R6: `almost_full` is 1 exactly when the current occupancy is strictly greater than `HI_MARK`. It follows the occupancy with no extra delay.
- R7: With `ASYNC_RD`=0, `empty` and `almost_empty` reflect the occupancy one cycle earlier. `empty` means that occupancy is 0, and `almost_empty` means it is strictly below `LO_MARK`.
- R8: An accepted write and an accepted read in the same cycle leave the occupancy unchanged. When full, a same-cycle write is dropped and the read proceeds. When empty, the read is dropped and the write proceeds.
- R9: With `ASYNC_RD`=1, `rd_data` shows the head entry combinationally, and `rd_valid` equals the read acceptance in the same cycle. `empty` and `almost_empty` follow the current occupancy.
- R10: Both pointers wrap from DEPTH-1 to 0, and order is kept across many wraps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Data to enqueue |
| rd_en | input | 1 | Read request |
| rd_data | output | DATA_W | Dequeued data |
| rd_valid | output | 1 | `rd_data` holds the result of an accepted read |
| full | output | 1 | DEPTH entries held |
| almost_full | output | 1 | Occupancy above HI_MARK |
| empty | output | 1 | No entries (lagged in registered mode) |
| almost_empty | output | 1 | Occupancy below LO_MARK (lagged in registered mode) |

## Verification
The hardest case to reach from the ports is a write and a read in the same cycle while the buffer sits exactly at full or at empty. In that case one request must be refused and the other accepted, and the lagged empty flag disagrees for a cycle with the true occupancy. The stimulus fills the buffer to DEPTH and then issues combined requests. It then drains to zero and issues combined requests again. A queue model predicts acceptance from its own size and checks every flag on every cycle. A registered-read and an asynchronous-read instance share the stimulus, so both latencies are checked against the same expected stream.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;
    typedef struct packed {
        logic full;
        logic almost_full;
        logic empty;
        logic almost_empty;
    } sfifo_flags_t;
endpackage

// File: rtl/sfifo_mem.sv
module sfifo_mem #(
    parameter int DATA_W   = 8,
    parameter int DEPTH    = 16,
    parameter bit ASYNC_RD = 1'b0,
    localparam int AW      = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              re,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);
    // storage array, no reset so it maps onto RAM
    logic [DATA_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) store[waddr] <= wdata;
    end

    generate
        if (ASYNC_RD) begin : g_async
            assign rdata = store[raddr];
        end else begin : g_sync
            logic [DATA_W-1:0] rdata_q;
            always_ff @(posedge clk) begin
                if (re) rdata_q <= store[raddr];
            end
            assign rdata = rdata_q;
        end
    endgenerate
endmodule

// File: rtl/sfifo_ctrl.sv
module sfifo_ctrl #(
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_req,
    input  logic          rd_req,
    output logic          wr_ok,
    output logic          rd_ok,
    output logic [AW-1:0] wr_ptr,
    output logic [AW-1:0] rd_ptr,
    output logic [CW-1:0] count
);
    localparam logic [AW-1:0] LAST_C = AW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL_C = CW'(DEPTH);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } ctrl_st_t;

    ctrl_st_t st_d, st_q;

    function automatic logic [AW-1:0] step_ptr(input logic [AW-1:0] p);
        return (p == LAST_C) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d  = st_q;
        wr_ok = wr_req && (st_q.cnt != FULL_C);
        rd_ok = rd_req && (st_q.cnt != '0);
        if (wr_ok) st_d.wp = step_ptr(st_q.wp);
        if (rd_ok) st_d.rp = step_ptr(st_q.rp);
        case ({wr_ok, rd_ok})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wr_ptr = st_q.wp;
    assign rd_ptr = st_q.rp;
    assign count  = st_q.cnt;
endmodule

// File: rtl/sfifo_flags.sv
module sfifo_flags
    import sfifo_pkg::*;
#(
    parameter int DEPTH    = 16,
    parameter int HI_MARK  = 12,
    parameter int LO_MARK  = 4,
    parameter bit ASYNC_RD = 1'b0,
    localparam int CW      = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] count,
    input  logic          rd_ok,
    output sfifo_flags_t  flags,
    output logic          rd_valid
);
    localparam logic [CW-1:0] FULL_C = CW'(DEPTH);
    localparam logic [CW-1:0] HI_C   = CW'(HI_MARK);
    localparam logic [CW-1:0] LO_C   = CW'(LO_MARK);

    logic [CW-1:0] shown;

    generate
        if (ASYNC_RD) begin : g_direct
            assign shown    = count;
            assign rd_valid = rd_ok;
        end else begin : g_lagged
            typedef struct packed {
                logic [CW-1:0] vis;
                logic          vld;
            } lag_st_t;
            lag_st_t lag_d, lag_q;

            always_comb begin
                lag_d.vis = count;
                lag_d.vld = rd_ok;
            end

            always_ff @(posedge clk) begin
                if (!rst_n) lag_q <= '0;
                else        lag_q <= lag_d;
            end

            assign shown    = lag_q.vis;
            assign rd_valid = lag_q.vld;
        end
    endgenerate

    always_comb begin
        flags.full         = (count == FULL_C);
        flags.almost_full  = (count > HI_C);
        flags.empty        = (shown == '0);
        flags.almost_empty = (shown < LO_C);
    end
endmodule

// File: rtl/sync_ram_fifo.sv
module sync_ram_fifo
    import sfifo_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int DEPTH    = 16,
    parameter int HI_MARK  = 12,
    parameter int LO_MARK  = 4,
    parameter bit ASYNC_RD = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              full,
    output logic              almost_full,
    output logic              empty,
    output logic              almost_empty
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    logic          wr_ok, rd_ok;
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] fill_cnt;
    sfifo_flags_t  flg;

    sfifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_req (wr_en),
        .rd_req (rd_en),
        .wr_ok  (wr_ok),
        .rd_ok  (rd_ok),
        .wr_ptr (wr_ptr),
        .rd_ptr (rd_ptr),
        .count  (fill_cnt)
    );

    sfifo_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH), .ASYNC_RD(ASYNC_RD)) u_mem (
        .clk   (clk),
        .we    (wr_ok),
        .waddr (wr_ptr),
        .wdata (wr_data),
        .re    (rd_ok),
        .raddr (rd_ptr),
        .rdata (rd_data)
    );

    sfifo_flags #(.DEPTH(DEPTH), .HI_MARK(HI_MARK), .LO_MARK(LO_MARK),
                  .ASYNC_RD(ASYNC_RD)) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .count    (fill_cnt),
        .rd_ok    (rd_ok),
        .flags    (flg),
        .rd_valid (rd_valid)
    );

    assign full         = flg.full;
    assign almost_full  = flg.almost_full;
    assign empty        = flg.empty;
    assign almost_empty = flg.almost_empty;
endmodule

// File: rtl/sync_ram_fifo_chk.sv
module sync_ram_fifo_chk #(
    parameter int DEPTH    = 16,
    parameter bit ASYNC_RD = 1'b0,
    localparam int CW      = $clog2(DEPTH) + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic          rd_en,
    input logic          full,
    input logic          empty,
    input logic          rd_valid,
    input logic [CW-1:0] cnt
);
    localparam logic [CW-1:0] FULL_C = CW'(DEPTH);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) cnt <= FULL_C); // R4
    AST_FULL_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (!rst_n) full && wr_en && !rd_en |=> full && $stable(cnt)); // R4
    AST_BOTH_KEEPS_COUNT: assert property (@(posedge clk) disable iff (!rst_n) wr_en && rd_en && cnt != '0 && cnt != FULL_C |=> $stable(cnt)); // R8
    AST_NOT_FULL_AND_EMPTY: assert property (@(posedge clk) disable iff (!rst_n) !(full && empty)); // R7

    generate
        if (!ASYNC_RD) begin : g_reg_checks
            AST_EMPTY_READ_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n) rd_en && cnt == '0 |=> !rd_valid); // R5
            AST_VALID_FROM_READ: assert property (@(posedge clk) disable iff (!rst_n) rd_en && cnt != '0 |=> rd_valid); // R3
            AST_EMPTY_LAGS: assert property (@(posedge clk) disable iff (!rst_n) 1'b1 |=> empty == ($past(cnt) == '0)); // R7
        end
    endgenerate
endmodule

bind sync_ram_fifo sync_ram_fifo_chk #(.DEPTH(DEPTH), .ASYNC_RD(ASYNC_RD)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .full     (full),
    .empty    (empty),
    .rd_valid (rd_valid),
    .cnt      (fill_cnt)
);

// File: tb/sync_ram_fifo_bench.sv
module sync_ram_fifo_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DW    = 8;
    localparam int DEPTH = 8;
    localparam int HI    = 5;
    localparam int LO    = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic rd_en = 1'b0;
    logic [DW-1:0] wr_data = '0;

    logic [DW-1:0] rd_data, rd_data_a;
    logic rv, rv_a, full, full_a, af, af_a, em, em_a, ae, ae_a;

    int n_chk = 0;
    int n_err = 0;
    bit done_flag = 1'b0;
    logic [DW-1:0] q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    sync_ram_fifo #(.DATA_W(DW), .DEPTH(DEPTH), .HI_MARK(HI), .LO_MARK(LO), .ASYNC_RD(1'b0)) u_sync_ram_fifo (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .rd_data(rd_data), .rd_valid(rv), .full(full), .almost_full(af),
        .empty(em), .almost_empty(ae)
    );

    sync_ram_fifo #(.DATA_W(DW), .DEPTH(DEPTH), .HI_MARK(HI), .LO_MARK(LO), .ASYNC_RD(1'b1)) u_sync_ram_fifo_async (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .rd_data(rd_data_a), .rd_valid(rv_a), .full(full_a), .almost_full(af_a),
        .empty(em_a), .almost_empty(ae_a)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    endtask

    // one clock cycle, entered and left at a falling edge
    task automatic cyc(input logic w, input logic [DW-1:0] d, input logic r);
        int pre = q.size();
        logic wa = w && (pre < DEPTH);
        logic ra = r && (pre > 0);
        logic [DW-1:0] exp_d = '0;
        wr_en = w; wr_data = d; rd_en = r;
        #1;
        chk("R9 async valid", rv_a, ra);
        if (ra) chk("R9 async data", rd_data_a, q[0]);
        chk("R9 async empty", em_a, pre == 0);
        chk("R9 async almost_empty", ae_a, pre < LO);
        @(posedge clk);
        if (ra) exp_d = q.pop_front();
        if (wa) q.push_back(d);
        @(negedge clk);
        chk("R3 valid strobe", rv, ra);
        if (ra) chk("R2 data order", rd_data, exp_d);
        chk("R4 full", full, q.size() == DEPTH);
        chk("R6 almost_full", af, q.size() > HI);
        chk("R7 empty lag", em, pre == 0);
        chk("R7 almost_empty lag", ae, pre < LO);
    endtask

    task automatic idle(); cyc(1'b0, '0, 1'b0); endtask

    task automatic t_reset_state();
        chk("R1 empty", em, 1); chk("R1 almost_empty", ae, 1);
        chk("R1 full", full, 0); chk("R1 almost_full", af, 0);
        chk("R1 valid", rv, 0);
    endtask

    task automatic t_fill_overflow();
        for (int i = 0; i < DEPTH + 3; i++) cyc(1'b1, DW'(8'h10 + i), 1'b0);
        chk("R4 full held", full, 1);
        for (int i = 0; i < DEPTH; i++) cyc(1'b0, '0, 1'b1);
        idle();
        chk("R4 drained empty", em, 1);
    endtask

    task automatic t_underflow();
        for (int i = 0; i < 3; i++) begin
            cyc(1'b0, '0, 1'b1);
            chk("R5 no valid on empty read", rv, 0);
        end
        cyc(1'b1, 8'hA5, 1'b0);
        idle();
        cyc(1'b0, '0, 1'b1);
        chk("R5 data after dropped reads", rd_data, 8'hA5);
    endtask

    task automatic t_latency();
        cyc(1'b1, 8'h3C, 1'b0);
        cyc(1'b0, '0, 1'b1);
        chk("R3 valid one cycle after read", rv, 1);
        idle();
        chk("R3 valid is a pulse", rv, 0);
    endtask

    task automatic t_simul();
        for (int i = 0; i < 3; i++) cyc(1'b1, DW'(8'h40 + i), 1'b0);
        for (int i = 0; i < 4; i++) cyc(1'b1, DW'(8'h50 + i), 1'b1);
        chk("R8 count held by combined ops", af, 0);
        while (q.size() < DEPTH) cyc(1'b1, DW'(8'h60 + q.size()), 1'b0);
        cyc(1'b1, 8'hEE, 1'b1);
        chk("R8 write refused at full", full, 0);
        while (q.size() > 0) cyc(1'b0, '0, 1'b1);
        idle();
        cyc(1'b1, 8'h77, 1'b1);
        chk("R8 read refused at empty", rv, 0);
        idle();
        chk("R8 write taken at empty", em, 0);
        cyc(1'b0, '0, 1'b1);
        chk("R8 data of write at empty", rd_data, 8'h77);
    endtask

    task automatic t_wrap();
        for (int i = 0; i < 4 * DEPTH; i++) begin
            cyc(1'b1, DW'(i * 7 + 1), 1'b0);
            cyc(1'b1, DW'(i * 7 + 2), 1'b1);
            cyc(1'b0, '0, 1'b1);
        end
        while (q.size() > 0) cyc(1'b0, '0, 1'b1);
        idle();
        chk("R10 empty after wraps", em, 1);
    endtask

    task automatic t_random();
        for (int i = 0; i < 500; i++)
            cyc(1'($urandom_range(0, 1)), DW'($urandom), 1'($urandom_range(0, 1)));
    endtask

    task automatic t_reset_midrun();
        for (int i = 0; i < 5; i++) cyc(1'b1, DW'(8'h90 + i), 1'b0);
        rst_n = 1'b0; wr_en = 1'b1; rd_en = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        q.delete();
        t_reset_state();
        chk("R1 async empty", em_a, 1);
        rst_n = 1'b1;
        cyc(1'b1, 8'h5A, 1'b0);
        cyc(1'b0, '0, 1'b1);
        chk("R1 fresh data after reset", rd_data, 8'h5A);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(11));
        repeat (3) @(posedge clk);
        @(negedge clk);
        t_reset_state();
        rst_n = 1'b1;
        t_fill_overflow();
        t_underflow();
        t_latency();
        t_simul();
        t_wrap();
        t_random();
        t_reset_midrun();
        finish_run();
    end
endmodule